// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Zero Bus Turnaround

This block is a synthesizable behavioural model of a synchronous flow-through SRAM. Data words are 18 bits wide and split into two 9-bit byte lanes. Every clock can move one word, and reads and writes may follow each other in any order with no idle cycles between them. Every control input is registered on the rising clock edge. Read data comes straight out of the array, through a merge stage, in the same cycle that the read is registered. Write data is taken one enabled clock after its address. A one-entry write buffer holds that data until the array commits it, and a read of the same address sees the buffered lanes in the meantime.

A two-bit burst counter lets one loaded address serve four accesses. The counter sequences only the two lowest address bits, in linear or interleaved order. An active-low clock enable freezes the whole pipeline. An asynchronous active-low output enable gates only the read-drive flag. A small state machine tracks which operation owns the data phase of the current cycle. Its states are ST_IDLE (deselected), ST_READ and ST_WRITE. Its transitions are:

- LOAD_RD: burst_go low, chip selected, wr_req_n high.
- LOAD_WR: burst_go low, chip selected, wr_req_n low.
- DESELECT: burst_go low, chip not selected, which leads to ST_IDLE.
- CONTINUE: burst_go high. The state is kept, and the counter advances unless the state is ST_IDLE.
- STALL: clk_en_n high. Every register holds.

Top module: `sram_ft_burst`

## Requirements
- R1: While rst_n is low and after its release with no load, the state is ST_IDLE and rdata_drive is 0.
- R2: A read registered at a clock edge presents the addressed word on rdata in the cycle following that edge. rdata_drive is 1 in that cycle while out_en_n is low.
- R3: Write data and lane_wr_n are sampled at the first enabled edge after the write address is registered. Lane bit n low writes bits [9n+8:9n], and any combination of lanes is valid.
- R4: Reads and writes to arbitrary addresses may be issued on consecutive enabled clocks in any order, and every read returns the latest written contents.
- R5: A read of an address whose write data was captured at the same edge returns that data on each written lane and the older contents on the other lanes.
- R6: With ilv_mode=0 (linear), beat k of a burst from base address b accesses low bits (b[1:0]+k) mod 4, with the upper bits unchanged.
- R7: With ilv_mode=1 (interleaved), beat k accesses low bits b[1:0] XOR k.
- R8: While clk_en_n is high, no operation loads, the burst counter does not advance, no write data is sampled, and the outputs keep their values.
- R9: The chip is selected only when sel_a_n=0, sel_b=1 and sel_c_n=0. A load without selection deselects the chip (rdata_drive=0), and a burst_go=1 cycle after that keeps it deselected.
- R10: During the data phase of a write, rdata_drive is 0 whatever the level of out_en_n.
- R11: out_en_n acts without a clock. When it is high, rdata_drive is 0, and when it falls during a read data phase, rdata_drive rises in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of control state |
| clk_en_n | input | 1 | Active-low clock enable; high stalls everything |
| burst_go | input | 1 | 0 = load new address and operation, 1 = advance burst |
| addr | input | AW (6) | Word address |
| wr_req_n | input | 1 | Active-low write request at load time |
| lane_wr_n | input | LANES (2) | Active-low lane write selects, sampled with write data |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | DW (18) | Write data |
| rdata | output | DW (18) | Read data |
| rdata_drive | output | 1 | High when the pad should drive rdata |

## Verification
The bench fills the whole array with back-to-back pipelined writes, reads all of it back, and then interleaves writes with reads of the same address under every lane mask. If the write buffer were not forwarded, those reads would return stale lanes. If the lane mapping were wrong, bits would appear in the wrong half. Bursts from each of the four starting offsets run in both orders, and a swapped order or an adder that carried into bit 2 would show up as the wrong word. Stalls are placed in a read burst and inside a write data phase, and deselects use each chip select in turn. A design that advanced under a stall, sampled data in a stalled cycle, or drove during a write phase or a deselect would be caught.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } op_state_e;

    // Low two address bits for burst beat k from base b.
    function automatic logic [1:0] beat_low(input logic [1:0] b,
                                            input logic [1:0] k,
                                            input logic       ilv);
        return ilv ? (b ^ k) : (b + k);
    endfunction

endpackage

// File: rtl/sram_burst_gen.sv
module sram_burst_gen
    import sram_ft_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] ld_addr,
    input  logic          ilv,
    output logic [AW-1:0] acc_addr,
    output logic [1:0]    beat
);

    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat   <= 2'd0;
        end else if (load) begin
            base_q <= ld_addr;
            beat   <= 2'd0;
        end else if (adv) begin
            beat   <= beat + 2'd1;
        end
    end

    always_comb begin
        acc_addr      = base_q;
        acc_addr[1:0] = beat_low(base_q[1:0], beat, ilv);
    end

endmodule

// File: rtl/sram_wr_buf.sv
module sram_wr_buf #(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int LW    = 9,
    localparam int DW   = LANES * LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             capture,
    input  logic [AW-1:0]    cap_addr,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    arr_rdata,
    output logic [DW-1:0]    fwd_rdata,
    output logic             cm_we,
    output logic [AW-1:0]    cm_addr,
    output logic [DW-1:0]    cm_data,
    output logic [LANES-1:0] cm_mask
);

    logic             vld_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    data_q;
    logic [LANES-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (en) begin
            vld_q <= capture;
        end
    end

    always_ff @(posedge clk) begin
        if (en && capture) begin
            addr_q <= cap_addr;
            data_q <= wdata;
            mask_q <= ~lane_wr_n;
        end
    end

    // Buffered write retires to the array at the next enabled edge.
    assign cm_we   = en && vld_q;
    assign cm_addr = addr_q;
    assign cm_data = data_q;
    assign cm_mask = mask_q;

    logic hit;
    assign hit = vld_q && (addr_q == rd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign fwd_rdata[l*LW +: LW] = (hit && mask_q[l]) ? data_q[l*LW +: LW]
                                                          : arr_rdata[l*LW +: LW];
    end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int LW    = 9,
    localparam int DW    = LANES * LW,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] wmask,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wmask[l]) mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sram_ft_burst.sv
module sram_ft_burst
    import sram_ft_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_n,
    input  logic             burst_go,
    input  logic [AW-1:0]    addr,
    input  logic             wr_req_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             ilv_mode,
    input  logic             out_en_n,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rdata_drive
);

    op_state_e st_q, st_d;

    logic          en, chip_sel, load, adv;
    logic [AW-1:0] acc_addr;
    logic [1:0]    beat;
    logic [DW-1:0] arr_rdata, fwd_rdata;
    logic          cm_we;
    logic [AW-1:0] cm_addr;
    logic [DW-1:0] cm_data;
    logic [LANES-1:0] cm_mask;

    assign en       = !clk_en_n;
    assign chip_sel = !sel_a_n && sel_b && !sel_c_n;
    assign load     = en && !burst_go && chip_sel;
    assign adv      = en && burst_go && (st_q != ST_IDLE);

    // Next-state decode.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!burst_go) begin
                    if (chip_sel) st_d = wr_req_n ? ST_READ : ST_WRITE;
                    else          st_d = ST_IDLE;
                end
            end
            ST_READ, ST_WRITE: begin
                if (!burst_go) begin
                    if (chip_sel) st_d = wr_req_n ? ST_READ : ST_WRITE;
                    else          st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register; a stalled clock extends the cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  st_q <= ST_IDLE;
        else if (en) st_q <= st_d;
    end

    // Output decode.
    always_comb begin
        rdata       = '0;
        rdata_drive = 1'b0;
        unique case (st_q)
            ST_READ: begin
                rdata       = fwd_rdata;
                rdata_drive = !out_en_n;
            end
            ST_IDLE, ST_WRITE: begin
                rdata_drive = 1'b0;
            end
            default: rdata_drive = 1'b0;
        endcase
    end

    sram_burst_gen #(.AW(AW)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .ld_addr  (addr),
        .ilv      (ilv_mode),
        .acc_addr (acc_addr),
        .beat     (beat)
    );

    sram_wr_buf #(.AW(AW), .LANES(LANES), .LW(LANE_W)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .capture   (st_q == ST_WRITE),
        .cap_addr  (acc_addr),
        .wdata     (wdata),
        .lane_wr_n (lane_wr_n),
        .rd_addr   (acc_addr),
        .arr_rdata (arr_rdata),
        .fwd_rdata (fwd_rdata),
        .cm_we     (cm_we),
        .cm_addr   (cm_addr),
        .cm_data   (cm_data),
        .cm_mask   (cm_mask)
    );

    sram_array #(.AW(AW), .LANES(LANES), .LW(LANE_W)) u_array (
        .clk   (clk),
        .we    (cm_we),
        .waddr (cm_addr),
        .wdata (cm_data),
        .wmask (cm_mask),
        .raddr (acc_addr),
        .rdata (arr_rdata)
    );

endmodule

// File: rtl/sram_ft_burst_chk.sv
module sram_ft_burst_chk
    import sram_ft_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       clk_en_n,
    input logic       burst_go,
    input logic       wr_req_n,
    input logic       sel_a_n,
    input logic       sel_b,
    input logic       sel_c_n,
    input logic       out_en_n,
    input logic       rdata_drive,
    input op_state_e  st_q,
    input logic [1:0] beat
);

    logic sel;
    assign sel = !sel_a_n && sel_b && !sel_c_n;

    p_load_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !burst_go && sel && wr_req_n) |=> (st_q == ST_READ));

    p_burst_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && burst_go && st_q != ST_IDLE) |=> (beat == $past(beat) + 2'd1));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(st_q) && $stable(beat)));

    p_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !burst_go && !sel) |=> !rdata_drive);

    p_wr_phase_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WRITE) |-> !rdata_drive);

    p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_drive);

endmodule

bind sram_ft_burst sram_ft_burst_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en_n    (clk_en_n),
    .burst_go    (burst_go),
    .wr_req_n    (wr_req_n),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .out_en_n    (out_en_n),
    .rdata_drive (rdata_drive),
    .st_q        (st_q),
    .beat        (beat)
);

// File: tb/sram_ft_burst_tb.sv
`timescale 1ns/1ps
module sram_ft_burst_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clk_en_n, burst_go, wr_req_n, sel_a_n, sel_b, sel_c_n, ilv_mode, out_en_n;
    logic [5:0]  addr;
    logic [1:0]  lane_wr_n;
    logic [17:0] wdata, rdata;
    logic        rdata_drive;

    int n_vec = 0;
    int n_bad = 0;

    // Requirement-level reference state.
    logic [17:0] ref_mem [64];
    int          m_st = 0;      // 0 idle, 1 read, 2 write
    logic [5:0]  m_base = '0;
    logic [1:0]  m_cnt = '0;
    logic [5:0]  m_cur = '0;
    logic        m_pend = 1'b0;
    logic [5:0]  m_paddr = '0;

    always #10 clk = ~clk;

    sram_ft_burst u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .burst_go(burst_go),
        .addr(addr), .wr_req_n(wr_req_n), .lane_wr_n(lane_wr_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .ilv_mode(ilv_mode), .out_en_n(out_en_n), .wdata(wdata),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare(input string req);
        logic exp_en;
        exp_en = (m_st == 1) && !out_en_n;
        chk(req, {17'd0, rdata_drive}, {17'd0, exp_en});
        if (m_st == 1) chk(req, rdata, ref_mem[m_cur]);
    endtask

    // Update the reference from current inputs, clock once, then compare.
    task automatic tick(input string req);
        logic [1:0] lo;
        if (!clk_en_n) begin
            if (m_pend) begin
                if (!lane_wr_n[0]) ref_mem[m_paddr][8:0]  = wdata[8:0];
                if (!lane_wr_n[1]) ref_mem[m_paddr][17:9] = wdata[17:9];
                m_pend = 1'b0;
            end
            if (!burst_go) begin
                if (!sel_a_n && sel_b && !sel_c_n) begin
                    m_st = wr_req_n ? 1 : 2;
                    m_base = addr;
                    m_cnt = 2'd0;
                end else begin
                    m_st = 0;
                end
            end else if (m_st != 0) begin
                m_cnt = m_cnt + 2'd1;
            end
            lo = ilv_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
            m_cur = {m_base[5:2], lo};
            if (m_st == 2) begin
                m_pend = 1'b1;
                m_paddr = m_cur;
            end
        end
        @(posedge clk);
        #5;
        compare(req);
    endtask

    task automatic cmd(input logic rd, input logic [5:0] a);
        clk_en_n = 1'b0; burst_go = 1'b0; wr_req_n = rd; addr = a;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    endtask

    task automatic nop();
        clk_en_n = 1'b0; burst_go = 1'b0; sel_a_n = 1'b1;
    endtask

    task automatic cont();
        clk_en_n = 1'b0; burst_go = 1'b1;
    endtask

    function automatic logic [17:0] pat(input int a);
        return 18'(a * 18'h0b3d) ^ 18'h15a3c;
    endfunction

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clk_en_n = 1'b0; burst_go = 1'b0; wr_req_n = 1'b1;
        addr = '0; lane_wr_n = 2'b00; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
        ilv_mode = 1'b0; out_en_n = 1'b0; wdata = '0;
        repeat (3) @(posedge clk);
        #5;
        chk("R1", {17'd0, rdata_drive}, 18'd0);
        rst_n = 1'b1;
        tick("R1");

        // R3/R4: pipelined fill of the whole array, all lanes.
        for (int a = 0; a < 64; a++) begin
            cmd(1'b0, 6'(a));
            lane_wr_n = 2'b00;
            wdata = (a == 0) ? 18'h0 : pat(a - 1);
            tick("R3");
        end
        nop(); wdata = pat(63); tick("R3");

        // R2: back-to-back read sweep.
        for (int a = 0; a < 64; a++) begin
            cmd(1'b1, 6'(a));
            tick("R2");
        end

        // R5/R10/R4: write then immediate read under each lane mask.
        for (int i = 0; i < 16; i++) begin
            cmd(1'b0, 6'((i * 7) % 64));
            tick("R10");
            cmd(1'b1, 6'((i * 7) % 64));
            wdata = pat(i + 100);
            lane_wr_n = 2'(i % 4);
            tick("R5");
            cmd(1'b1, 6'((i * 7 + 1) % 64));
            tick("R4");
            cmd(1'b1, 6'((i * 7) % 64));
            tick("R3");
        end
        lane_wr_n = 2'b00;

        // R6/R7: bursts from every start offset, both orders.
        for (int m = 0; m < 2; m++) begin
            ilv_mode = 1'(m);
            for (int b = 0; b < 4; b++) begin
                cmd(1'b1, 6'(36 + b));
                tick(m ? "R7" : "R6");
                for (int k = 1; k < 4; k++) begin
                    cont();
                    tick(m ? "R7" : "R6");
                end
            end
        end

        // R6: linear write burst from an odd offset, then read back.
        ilv_mode = 1'b0;
        cmd(1'b0, 6'd21); tick("R6");
        for (int k = 0; k < 3; k++) begin
            cont(); wdata = pat(200 + k); tick("R6");
        end
        nop(); wdata = pat(203); tick("R6");
        for (int a = 20; a < 24; a++) begin
            cmd(1'b1, 6'(a)); tick("R6");
        end

        // R8: stall inside a read burst.
        ilv_mode = 1'b1;
        cmd(1'b1, 6'd5); tick("R8");
        clk_en_n = 1'b1; burst_go = 1'b0; addr = 6'd9; wr_req_n = 1'b0;
        tick("R8");
        tick("R8");
        cont(); tick("R8");
        cont(); tick("R8");

        // R8: stall inside a write data phase.
        cmd(1'b0, 6'd30); tick("R8");
        clk_en_n = 1'b1; wdata = 18'h3ffff; lane_wr_n = 2'b00; tick("R8");
        cmd(1'b1, 6'd30); wdata = pat(300); lane_wr_n = 2'b00; tick("R8");
        cmd(1'b1, 6'd30); tick("R8");

        // R9: each chip select inactive in turn, then continue.
        for (int c = 0; c < 3; c++) begin
            cmd(1'b1, 6'd3); tick("R9");
            cmd(1'b1, 6'd3);
            if (c == 0) sel_a_n = 1'b1;
            if (c == 1) sel_b = 1'b0;
            if (c == 2) sel_c_n = 1'b1;
            tick("R9");
            cont(); tick("R9");
        end

        // R11: asynchronous output enable.
        cmd(1'b1, 6'd4); out_en_n = 1'b1; tick("R11");
        out_en_n = 1'b0; #1; compare("R11");
        out_en_n = 1'b1; #1; compare("R11");
        out_en_n = 1'b0;
        // R10: write phase stays quiet with the output enabled.
        cmd(1'b0, 6'd4); tick("R10");
        nop(); wdata = pat(400); tick("R10");
        cmd(1'b1, 6'd4); tick("R3");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule